// File: doc/BRIEF.md
# Reloadable Down-Counting Timer with Capture and Compare

This block is an 8-bit synchronous down counter with a small register file on a simple single-cycle bus. Software programs a period and a compare value while the timer is stopped, then sets the run bit. While running, the count steps down once per clock. When it reaches zero, the next clock reloads it from the period register. One full cycle therefore spans period + 1 clocks.

Two outputs are produced. The terminal-count output marks the clocks where the count is zero, either as a half-cycle pulse in the low phase of the clock or as a full clock wide pulse. The compare output shows whether the count is below the compare value, or at or below it. A capture input copies the running count into the compare register. An interrupt line follows either the terminal count or a rising edge of the compare output.

Several register accesses have side effects that depend on the run bit. A period write while stopped also loads the count. A count read while stopped copies the count into the compare register. Bus writes to the compare register are ignored while running.

Top module: `reloadTimer`

Register addresses: 0 = count (reads 0), 1 = period (write only, reads 0), 2 = compare (read/write), 3 = control. Control bits: bit 0 run, bit 1 full-cycle terminal count, bit 2 compare type (1 = at-or-below), bit 3 interrupt source (1 = compare edge).

## Requirements
- R1: After reset the timer is stopped. Count, period, compare value and control are all 0. terminalCount, compareOut and irqOut are low.
- R2: While running, the count decrements by one on each clock. On the clock after the count is 0, it reloads from the period register, so one cycle spans period + 1 clocks.
- R3: While stopped, a bus write to address 1 sets the period and also loads the same value into the count.
- R4: While running, a write to address 1 changes only the period register. The count is not changed. The new value is used at the next reload, and a reload takes the period held before that clock edge.
- R5: With control bit 1 = 0 (half-cycle mode), terminalCount is high only while the timer is running, the count is 0 and clk is low. With period 0 this gives the inverse of clk.
- R6: With control bit 1 = 1 (full-cycle mode), terminalCount is high for the whole clock while the timer is running and the count is 0. With period 0 it stays high.
- R7: While running, a high captureIn copies the current count into the compare register on that clock edge. While stopped, captureIn is ignored.
- R8: compareOut is low while the timer is stopped. While running, it is count < compare value when control bit 2 = 0, and count <= compare value when control bit 2 = 1.
- R9: A bus write to address 2 sets the compare value while the timer is stopped. The same write is ignored while running.
- R10: While stopped, a bus read of address 0 copies the count into the compare register. While running, such a read has no effect. Reads of addresses 0 and 1 return 0.
- R11: irqOut is low while stopped. While running, with control bit 3 = 0 it equals the full-clock terminal count (count is 0). With control bit 3 = 1 it is high on the first clock in which compareOut is high after having been low.
- R12: busRdata returns the compare value at address 2, and the control bits in bits 3:0 at address 3, without any clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 2 | Register address |
| busWr | input | 1 | Write strobe, taken at the rising edge |
| busRd | input | 1 | Read strobe; its side effects take place at the rising edge |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data |
| captureIn | input | 1 | Capture request |
| terminalCount | output | 1 | Terminal-count output |
| compareOut | output | 1 | Compare result |
| irqOut | output | 1 | Interrupt pulse |

## Verification
Two things can land on the same clock edge. A capture can arrive on the clock where the count reloads, and a period write can arrive on that same terminal-count clock. The bench drives both at once: it raises captureIn on the zero-count clock and issues a period write on another terminal-count clock. The expected result is that the capture takes the value 0 and that the reload uses the old period. A bus write to the compare register is also issued in the same cycle as a capture while the timer is running; the capture must win and the write must be dropped. The bench judges all of these against a behavioural model every clock, checking both clock phases for the terminal-count output.

// File: rtl/timerPkg.sv
package timerPkg;
  typedef enum logic [1:0] {
    ADDR_COUNT  = 2'd0,
    ADDR_PERIOD = 2'd1,
    ADDR_CMP    = 2'd2,
    ADDR_CTRL   = 2'd3
  } regAddr_t;

  localparam int CTRL_BITS = 4;

  typedef struct packed {
    logic loadPeriod;
    logic loadCount;
    logic writeCmp;
    logic captureCmp;
    logic snapCmp;
    logic run;
    logic fullTc;
    logic cmpLe;
    logic irqCmp;
  } ctrlStrobes_t;
endpackage

// File: rtl/timerCtrl.sv
module timerCtrl
  import timerPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [WIDTH-1:0] busWdata,
  input  logic             captureIn,
  output ctrlStrobes_t     strb,
  output logic [CTRL_BITS-1:0] ctrlBits
);
  logic [CTRL_BITS-1:0] ctrlReg;
  regAddr_t addr;

  assign addr = regAddr_t'(busAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (busWr && addr == ADDR_CTRL) ctrlReg <= busWdata[CTRL_BITS-1:0];
  end

  always_comb begin
    strb.run        = ctrlReg[0];
    strb.fullTc     = ctrlReg[1];
    strb.cmpLe      = ctrlReg[2];
    strb.irqCmp     = ctrlReg[3];
    strb.loadPeriod = busWr && addr == ADDR_PERIOD;
    strb.loadCount  = busWr && addr == ADDR_PERIOD && !ctrlReg[0];
    strb.writeCmp   = busWr && addr == ADDR_CMP && !ctrlReg[0];
    strb.captureCmp = captureIn && ctrlReg[0];
    strb.snapCmp    = busRd && addr == ADDR_COUNT && !ctrlReg[0];
  end

  assign ctrlBits = ctrlReg;

  // R9: no bus write to compare may be granted while running
  assert_cmp_write_lock_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBits[0] |-> !strb.writeCmp);
  // R7: capture is never granted while stopped
  assert_capture_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBits[0] |-> !strb.captureCmp);
endmodule

// File: rtl/timerDatapath.sv
module timerDatapath
  import timerPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] cmpVal,
  output logic             terminalCount,
  output logic             compareOut,
  output logic             irqOut
);
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic [WIDTH-1:0] countReg, periodReg, cmpReg;
  logic             cmpPrev, atZero;

  assign atZero = countReg == ZERO;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countReg  <= '0;
      periodReg <= '0;
      cmpReg    <= '0;
      cmpPrev   <= 1'b0;
    end else begin
      if (strb.loadPeriod) periodReg <= busWdata;
      if (strb.loadCount) countReg <= busWdata;
      else if (strb.run) countReg <= atZero ? periodReg : countReg - ONE;
      if (strb.writeCmp) cmpReg <= busWdata;
      else if (strb.captureCmp || strb.snapCmp) cmpReg <= countReg;
      cmpPrev <= compareOut;
    end
  end

  always_comb begin
    compareOut    = strb.run && (strb.cmpLe ? (countReg <= cmpReg) : (countReg < cmpReg));
    terminalCount = strb.run && atZero && (strb.fullTc || !clk);
    irqOut        = strb.run && (strb.irqCmp ? (compareOut && !cmpPrev) : atZero);
  end

  assign cmpVal = cmpReg;

  // R2: a running nonzero count steps down by one
  assert_decrement_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !atZero) |=> countReg == $past(countReg) - ONE);
  // R4: reload uses the period held before the edge
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && atZero) |=> countReg == $past(periodReg));
  // R3: stopped period write lands in the count
  assert_stopped_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCount |=> countReg == $past(busWdata));
  // R9: compare value only moves through a granted path
  assert_cmp_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.writeCmp && !strb.captureCmp && !strb.snapCmp) |=> $stable(cmpReg));
  // R6: full-cycle mode holds the output through a zero count
  assert_full_tc_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && strb.fullTc && atZero) |-> terminalCount);
endmodule

// File: rtl/reloadTimer.sv
module reloadTimer
  import timerPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic             captureIn,
  output logic             terminalCount,
  output logic             compareOut,
  output logic             irqOut
);
  ctrlStrobes_t          strb;
  logic [CTRL_BITS-1:0]  ctrlBits;
  logic [WIDTH-1:0]      cmpVal;

  timerCtrl #(.WIDTH(WIDTH)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .captureIn(captureIn), .strb(strb), .ctrlBits(ctrlBits)
  );

  timerDatapath #(.WIDTH(WIDTH)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata), .cmpVal(cmpVal),
    .terminalCount(terminalCount), .compareOut(compareOut), .irqOut(irqOut)
  );

  always_comb begin
    case (regAddr_t'(busAddr))
      ADDR_CMP:  busRdata = cmpVal;
      ADDR_CTRL: busRdata = WIDTH'(ctrlBits);
      default:   busRdata = '0;
    endcase
  end

  // R11: no interrupt while stopped
  assert_irq_stopped_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBits[0] |-> !irqOut);
endmodule

// File: tb/sim_reloadTimer.sv
module sim_reloadTimer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0, captureIn = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic terminalCount, compareOut, irqOut;

  reloadTimer u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .captureIn(captureIn),
    .terminalCount(terminalCount), .compareOut(compareOut), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  int vectors = 0, miscompares = 0, cycles = 0;
  string tag = "R1";

  int mCount = 0, mPeriod = 0, mCmp = 0;
  bit mEn = 0, mFull = 0, mLe = 0, mIrqSel = 0, mCmpPrev = 0;

  function automatic bit modelCmp();
    return mEn && (mLe ? (mCount <= mCmp) : (mCount < mCmp));
  endfunction

  function automatic int modelRdata(int a);
    if (a == 2) return mCmp;
    if (a == 3) return {mIrqSel, mLe, mFull, mEn};
    return 0;
  endfunction

  task automatic chk(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkHigh();
    chk("terminalCount(high phase)", terminalCount, mEn && mCount == 0 && mFull);
    chk("compareOut R8", compareOut, modelCmp());
    chk("irqOut R11", irqOut,
        mEn && (mIrqSel ? (modelCmp() && !mCmpPrev) : (mCount == 0)));
  endtask

  task automatic checkLow();
    chk("terminalCount(low phase)", terminalCount, mEn && mCount == 0);
    chk("busRdata R12", busRdata, modelRdata(busAddr));
  endtask

  task automatic step(int a = 0, bit wr = 0, bit rd = 0, int wd = 0, bit cap = 0);
    int oc, op;
    bit oen, cmpOld;
    busAddr = 2'(a); busWr = wr; busRd = rd; busWdata = 8'(wd); captureIn = cap;
    @(posedge clk);
    oc = mCount; op = mPeriod; oen = mEn; cmpOld = modelCmp();
    mCmpPrev = cmpOld;
    if (wr && a == 3) begin
      mEn = wd[0]; mFull = wd[1]; mLe = wd[2]; mIrqSel = wd[3];
    end
    if (wr && a == 1) begin
      mPeriod = wd;
      if (!oen) mCount = wd;
    end
    if (wr && a == 2 && !oen) mCmp = wd;
    if (oen) begin
      mCount = (oc == 0) ? op : oc - 1;
      if (cap) mCmp = oc;
    end
    if (!oen && rd && a == 0) mCmp = oc;
    #5 checkHigh();
    #10 checkLow();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #15;
    tag = "R1";
    checkHigh();
    checkLow();
    busAddr = 2'd3; #1 chk("control after reset R1", busRdata, 0);
    busAddr = 2'd0;
    rstN = 1'b1;

    tag = "R3 R9 R12";
    step(1, 1, 0, 5);
    step(2, 1, 0, 3);
    step(2);
    step(1, 1, 0, 4);
    step(0, 1, 0, 0);

    tag = "R2 R5 R8 R11";
    step(3, 1, 0, 8'h01);
    idle(12);

    tag = "R4";
    step(1, 1, 0, 2);
    idle(3);
    while (mCount != 0) step();
    step(1, 1, 0, 6);
    idle(12);

    tag = "R7 R9";
    while (mCount != 3) step();
    step(2, 1, 0, 8'hEE, 1);
    step(2);
    while (mCount != 0) step();
    step(2, 0, 0, 0, 1);
    idle(2);
    step(0, 0, 1);
    step(2);

    tag = "R6 R8 R11";
    step(3, 1, 0, 8'h0F);
    idle(16);
    step(3, 1, 0, 8'h0B);
    idle(8);

    tag = "R10 R7";
    step(3, 1, 0, 8'h00);
    step(2, 1, 0, 8'h00);
    step(0, 0, 0, 0, 1);
    step(2);
    step(0, 0, 1);
    step(2);
    step(1, 0, 1);

    tag = "R5 R6";
    step(1, 1, 0, 0);
    step(3, 1, 0, 8'h01);
    idle(4);
    step(3, 1, 0, 8'h03);
    idle(4);
    step(3, 1, 0, 8'h00);

    tag = "R3";
    step(1, 1, 0, 8'hFF);
    step(3, 1, 0, 8'h05);
    idle(6);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule